// File: doc/BRIEF.md
# Stopwatch and Periodic Interval Timer

This block divides the master clock down to a slow tick and drives two counters from it. The first is a 12-bit stopwatch that counts ticks without stopping and can be preset by a register write. The second is an 8-bit interval timer. When its setting is nonzero it raises a pending interrupt once per period, and it reloads itself from the setting every time it expires.

Software reaches three registers over a small 16-bit port. Address 0 holds the stopwatch, address 1 holds the timer setting and address 2 holds the interrupt-enable mask. The pending flag stays set until it is acknowledged. The interrupt line shows the flag only while the timer-enable bit of the mask is set. Mask bit 2 is brought out as the enable for a second, level-2 interrupt source that lives elsewhere.

Top module: `swatch_itimer`

## Requirements
- R1: A tick occurs once every TICK_DIV master clocks (default 1536), and the stopwatch (address 0, bits 11:0) advances by one on each tick.
- R2: The stopwatch wraps from 0xFFF to 0x000.
- R3: A write to address 0 loads the stopwatch with bits 11:0 of the written data. A read of address 0 returns 0 in bits 15:12.
- R4: The timer setting at address 1 keeps only bits 7:0 of a write. A read returns 0 in bits 15:8.
- R5: A timer setting of 0 never makes the interrupt pending.
- R6: With a setting N in the range 1 to 255, the interrupt becomes pending once every N+1 ticks, and the counter reloads from the setting at each expiry.
- R7: A write to the timer setting reloads the counter on the next tick after the write. The first expiry then follows N ticks after that reload.
- R8: The mask register at address 2 keeps only bits 6:1 of a write. All other bits read as 0.
- R9: The pending flag stays set until a cycle with irq_ack high. irq_lvl3 is high exactly when the flag is set and mask bit 3 is 1.
- R10: lvl2_en equals mask bit 2.
- R11: After reset every register reads 0, irq_lvl3 is low and lvl2_en is low.
- R12: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 stopwatch, 1 timer, 2 mask |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_ack | input | 1 | Clears the pending timer interrupt |
| irq_lvl3 | output | 1 | Timer interrupt request |
| lvl2_en | output | 1 | Level-2 interrupt enable (mask bit 2) |

## Verification
A fault in the prescaler phase shows up at address 0 within one tick period, because the stopwatch steps one clock early or late. A fault in the timer countdown or in the reload does not show up at once. It appears on irq_lvl3 at the next expiry, so an off-by-one period is seen up to N+1 ticks after it is introduced. A fault in the pending flag shows up on the first cycle after an acknowledge, or on the first cycle after the interrupt is left unacknowledged.

// File: rtl/swatch_itimer.sv
module swatch_itimer #(
  parameter int TICK_DIV = 1536,
  parameter int SW_W     = 12,
  parameter int TMR_W    = 8,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_ack,
  output logic          irq_lvl3,
  output logic          lvl2_en
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0]    pcnt;
  logic [SW_W-1:0]  sw;
  logic [TMR_W-1:0] tset, cnt;
  logic [6:1]       mask;
  logic             ld, pend, tick, expire;

  wire wr_sw   = reg_we && reg_addr == 2'd0;
  wire wr_tmr  = reg_we && reg_addr == 2'd1;
  wire wr_mask = reg_we && reg_addr == 2'd2;

  assign tick   = (pcnt == PW'(TICK_DIV - 1));
  assign expire = tick && !ld && cnt == TMR_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sw <= '0;
    else if (wr_sw)  sw <= reg_wdata[SW_W-1:0];
    else if (tick)   sw <= sw + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tset <= '0;
      ld   <= 1'b0;
      cnt  <= '0;
    end else begin
      if (tick) begin
        if (ld || cnt == '0) cnt <= tset;
        else                 cnt <= cnt - 1'b1;
      end
      if (wr_tmr) begin
        tset <= reg_wdata[TMR_W-1:0];
        ld   <= 1'b1;
      end else if (tick) begin
        ld   <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else        pend <= expire | (pend & ~irq_ack);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        mask <= '0;
    else if (wr_mask)  mask <= reg_wdata[6:1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[SW_W-1:0]  = sw;
      2'd1:    reg_rdata[TMR_W-1:0] = tset;
      2'd2:    reg_rdata[6:1]       = mask;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_lvl3 = pend & mask[3];
  assign lvl2_en  = mask[2];

  AST_SW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_sw) |=> sw == $past(sw) + 1'b1);                  // R1
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_sw) |=> $stable(sw));                            // R1
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw |=> sw == $past(reg_wdata[SW_W-1:0]));                   // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tset == '0 && !ld && cnt == '0 && !pend) |=> !pend);          // R5
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !irq_ack) |=> pend);                                  // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !expire) |=> !pend);                               // R9
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ld) |=> cnt == $past(tset));                          // R7
endmodule

// File: tb/test_swatch_itimer.sv
module test_swatch_itimer;
  localparam int DIV = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, irq_ack = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq_lvl3, lvl2_en;

  int tests = 0, fails = 0, cyc = 0, irq_cycles = 0;
  bit done = 0;

  swatch_itimer #(.TICK_DIV(DIV)) i_swatch_itimer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_lvl3(irq_lvl3), .lvl2_en(lvl2_en));

  always #2.5 clk = ~clk;

  // behavioural reference model
  int m_pc, m_sw, m_tmr, m_cnt, m_mask;
  bit m_ld, m_pend;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pc = 0; m_sw = 0; m_tmr = 0; m_cnt = 0; m_mask = 0; m_ld = 0; m_pend = 0;
    end else begin
      bit tk, ex;
      tk = (m_pc == DIV - 1);
      m_pc = tk ? 0 : m_pc + 1;
      if (reg_we && reg_addr == 0) m_sw = reg_wdata & 16'hFFF;
      else if (tk) m_sw = (m_sw + 1) % 4096;
      ex = 0;
      if (tk) begin
        if (m_ld) m_cnt = m_tmr;
        else if (m_cnt == 1) begin m_cnt = 0; ex = 1; end
        else if (m_cnt == 0) m_cnt = m_tmr;
        else m_cnt = m_cnt - 1;
        m_ld = 0;
      end
      m_pend = ex | (m_pend & !irq_ack);
      if (reg_we && reg_addr == 1) begin m_ld = 1; m_tmr = reg_wdata & 16'hFF; end
      if (reg_we && reg_addr == 2) m_mask = reg_wdata & 16'h7E;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_sw;
      1: return m_tmr;
      2: return m_mask;
      default: return 0;
    endcase
  endfunction

  // every-clock comparison (R1 R2 R6 R7 R9 R10)
  always @(negedge clk) if (rst_n && !done) begin
    if (irq_lvl3) irq_cycles++;
    tests++;
    if (reg_rdata !== 16'(exp_rd(int'(reg_addr))) ||
        irq_lvl3 !== (m_pend && m_mask[3]) || lvl2_en !== m_mask[2]) begin
      fails++;
      $display("FAIL R1 R6 R7 R9 R10 model cycle %0d: rdata=%h irq=%b l2=%b expected rdata=%h irq=%b l2=%b",
        cyc, reg_rdata, irq_lvl3, lvl2_en, 16'(exp_rd(int'(reg_addr))),
        m_pend && m_mask[3], m_mask[2]);
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 2'(a); #1 d = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int t);
    int k = 0;
    while (!irq_lvl3 && k < 20000) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, w, t1, t2, n0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 3; a++) begin rd(a, v); chk("R11 reset read", v, 0); end
    chk("R11 reset irq", irq_lvl3, 0); chk("R11 reset lvl2", lvl2_en, 0);

    rd(0, v); idle(DIV - 1); rd(0, w); chk("R1 one tick per period", w - v, 1);

    wr(0, 16'hABCD); rd(0, v); chk("R3 masked load", v, 16'h0BCD);
    wr(0, 16'h0FFF); rd(0, v); chk("R2 preset", v, 16'h0FFF);
    idle(DIV); rd(0, v); chk("R2 wrap", v, 0);

    wr(1, 16'h1234); rd(1, v); chk("R4 timer 8 bits", v, 16'h0034);
    wr(2, 16'hFFFF); rd(2, v); chk("R8 mask bits", v, 16'h007E);
    chk("R10 lvl2 on", lvl2_en, 1);
    rd(3, v); chk("R12 address 3", v, 0);

    wr(1, 0); wr(2, 16'h0008); ack;
    n0 = irq_cycles; idle(20 * DIV);
    chk("R5 zero setting quiet", irq_cycles - n0, 0);
    chk("R10 lvl2 off", lvl2_en, 0);

    wr(1, 3);
    wait_irq(t1); ack; wait_irq(t2);
    chk("R6 period N+1 ticks", t2 - t1, 4 * DIV);
    wr(1, 1); ack;
    wait_irq(t1); ack; wait_irq(t2);
    chk("R6 R7 period after rewrite", t2 - t1, 2 * DIV);

    idle(5); chk("R9 held without ack", irq_lvl3, 1);
    wr(2, 0); chk("R9 gated by mask", irq_lvl3, 0);
    wr(2, 16'h0008); chk("R9 ungated", irq_lvl3, 1);
    wr(1, 0); ack; chk("R9 ack clears", irq_lvl3, 0);

    wr(1, 7); idle(30 * DIV); wr(0, 0); idle(5 * DIV);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule